// File: doc/BRIEF.md
# Ethernet Flow-Control Pause Timer

This block handles received flow-control pause requests for a full-duplex Ethernet MAC. A receive parser hands it, once per finished frame, the destination address, the type field, the control opcode, the requested pause quanta and a flag that says the frame passed its FCS and error checks. The block decides whether the frame is a genuine pause request. If it is, the block raises a pulse for the statistics counter, raises an interrupt pulse if that interrupt is enabled, and, in full-duplex mode, loads the requested quanta into a countdown register.

While pausing is enabled and the countdown is non-zero, the block tells the transmitter not to start another frame. A frame already on the wire is not cut short. The countdown falls by one every 128 clocks, which is one 512-bit-time quantum on a nibble-wide receive clock. When pausing is enabled it counts only while the transmitter is idle. A test mode makes it count on every clock. When it reaches zero, a second maskable interrupt pulse is raised.

Top module: `pause_flow_ctl`

## Requirements
- R1: A frame is valid only if all three of these hold: its destination equals 48'h0180C2000001 or `cfg_station_addr`; its type equals 16'h8808; its opcode equals 16'h0001. Any other frame changes no output.
- R2: A frame whose `rx_frame_ok` is low has no effect on `pause_remaining`, `irq_pause_rx` or `stat_pause_rx_inc`, even if its fields match.
- R3: In full-duplex mode (`cfg_full_duplex`=1), a valid frame overwrites `pause_remaining` with `rx_pause_quanta` on the clock edge that samples `rx_frame_done`, whatever the value of `cfg_pause_en`. In half-duplex mode the value is not loaded.
- R4: Each valid frame produces a one-cycle `stat_pause_rx_inc` pulse in the cycle after `rx_frame_done`, in either duplex mode. In that same cycle `irq_pause_rx` pulses only if `irq_en_pause_rx`=1.
- R5: `tx_hold` is high exactly when `cfg_pause_en`=1, `cfg_full_duplex`=1 and `pause_remaining` is non-zero.
- R6: With `cfg_fast_count`=0, a running countdown decrements once per 128 running clocks. The first decrement comes 128 edges after a load, because every load restarts the quantum prescaler.
- R7: With `cfg_pause_en`=1, the countdown holds while `tx_busy`=1. With `cfg_pause_en`=0, it runs whatever the value of `tx_busy`.
- R8: With `cfg_fast_count`=1, a running countdown decrements on every clock.
- R9: When a decrement takes `pause_remaining` from 1 to 0, `irq_pause_done` pulses for one cycle if `irq_en_pause_done`=1. Loading a value of 0 raises no pulse.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (receive clock domain) |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_full_duplex | input | 1 | 1 = full-duplex operation |
| cfg_pause_en | input | 1 | Honour received pause requests |
| cfg_fast_count | input | 1 | Test mode: decrement every clock |
| cfg_station_addr | input | 48 | Programmed unicast address that also accepts pause frames |
| irq_en_pause_rx | input | 1 | Enable for the pause-received interrupt |
| irq_en_pause_done | input | 1 | Enable for the pause-expired interrupt |
| rx_frame_done | input | 1 | One-cycle strobe: the frame fields are valid |
| rx_dst_addr | input | 48 | Destination address of the frame |
| rx_type | input | 16 | Type/length field |
| rx_opcode | input | 16 | Control opcode |
| rx_pause_quanta | input | 16 | Requested pause time in quanta |
| rx_frame_ok | input | 1 | 1 = frame passed FCS and error checks |
| tx_busy | input | 1 | Transmitter is sending a frame |
| tx_hold | output | 1 | Do not start a new transmit frame |
| pause_remaining | output | 16 | Current countdown value |
| irq_pause_rx | output | 1 | Pause-received interrupt pulse |
| irq_pause_done | output | 1 | Pause-expired interrupt pulse |
| stat_pause_rx_inc | output | 1 | Pause-frame statistic increment |

## Verification
The bench targets these corner cases:
- **Matching.** Frames that match on the address but miss on the type, the opcode or the FCS check. A matcher that checks too few fields would load the counter or pulse the statistic on them.
- **Duplex and enable gating.** A half-duplex pause frame, which must still interrupt but must not load, and a load while pausing is disabled, which must still take effect. Confused gating would show up as a wrong `pause_remaining`.
- **Quantum timing.** The 128-clock quantum is checked one cycle either side of its end, both after a first load and after a reload mid-quantum. An off-by-one or a prescaler that is not restarted moves the first decrement.
- **Idle-only counting and expiry.** Counting that ignores transmitter activity would decrement while frozen. An expiry pulse that also fired on a load of zero, or that ignored its enable, would be caught at `irq_pause_done`.

// File: rtl/pause_pkg.sv
// Package: shared constants for the pause-frame timer.
// Assumes: standard MAC-control encodings for pause requests.
package pause_pkg;
    localparam int ADDR_W  = 48;
    localparam int FIELD_W = 16;
    localparam int QUANTA_W = 16;
    localparam logic [ADDR_W-1:0]  CTRL_MCAST_ADDR = 48'h0180C2000001;
    localparam logic [FIELD_W-1:0] MAC_CTRL_TYPE   = 16'h8808;
    localparam logic [FIELD_W-1:0] PAUSE_OPCODE    = 16'h0001;
endpackage

// File: rtl/pause_frame_qualify.sv
// Module: pause_frame_qualify
// Decides whether a finished received frame is a valid pause request.
// Assumes: the frame fields are stable in the cycle where frame_done_i is high.
module pause_frame_qualify
    import pause_pkg::*;
(
    input  logic                frame_done_i,
    input  logic                frame_ok_i,
    input  logic [ADDR_W-1:0]   dst_i,
    input  logic [FIELD_W-1:0]  type_i,
    input  logic [FIELD_W-1:0]  opcode_i,
    input  logic [ADDR_W-1:0]   station_i,
    output logic                valid_o
);
    logic dst_hit;
    logic ctrl_hit;

    // Destination check: the reserved multicast or the programmed station address.
    always_comb dst_hit = (dst_i == CTRL_MCAST_ADDR) || (dst_i == station_i);

    // Control-frame check: the type and the opcode must both match.
    always_comb ctrl_hit = (type_i == MAC_CTRL_TYPE) && (opcode_i == PAUSE_OPCODE);

    // Final qualification: an errored frame is always discarded.
    always_comb valid_o = frame_done_i && frame_ok_i && dst_hit && ctrl_hit;
endmodule

// File: rtl/pause_quanta_prescaler.sv
// Module: pause_quanta_prescaler
// Produces one tick per QUANTUM_CLKS running clocks, or one per clock in fast mode.
// Assumes: restart_i zeroes the phase so that a full quantum follows every load.
module pause_quanta_prescaler #(
    parameter int QUANTUM_CLKS = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    input  logic fast_i,
    output logic tick_o
);
    generate
        if (QUANTUM_CLKS <= 1) begin : g_every_clock
            // Degenerate quantum: a tick on every running clock.
            always_comb tick_o = run_i && !restart_i;
        end else begin : g_divider
            localparam int PW = $clog2(QUANTUM_CLKS);
            localparam logic [PW-1:0] LAST = PW'(QUANTUM_CLKS - 1);
            logic [PW-1:0] phase_q;
            logic          at_end;

            // End-of-quantum detect, overridden by fast mode.
            always_comb at_end = fast_i || (phase_q == LAST);

            // Tick only on a running clock that is not a restart.
            always_comb tick_o = run_i && !restart_i && at_end;

            // Phase counter: cleared by reset, restart or wrap; advances while running.
            always_ff @(posedge clk) begin
                if (!rst_n || restart_i) begin
                    phase_q <= '0;
                end else if (run_i) begin
                    phase_q <= at_end ? '0 : phase_q + 1'b1;
                end
            end

            // R6
            phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
                phase_q <= LAST);
        end
    endgenerate
endmodule

// File: rtl/pause_time_counter.sv
// Module: pause_time_counter
// Holds the remaining pause quanta: loads on request, decrements on tick.
// Assumes: a load takes priority over a decrement in the same cycle.
module pause_time_counter #(
    parameter int QUANTA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [QUANTA_W-1:0] load_val_i,
    input  logic                tick_i,
    output logic [QUANTA_W-1:0] count_o,
    output logic                expired_o
);
    logic [QUANTA_W-1:0] count_q;
    logic                expired_q;

    // Countdown register, plus a one-cycle pulse when a decrement reaches zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q   <= '0;
            expired_q <= 1'b0;
        end else begin
            expired_q <= 1'b0;
            if (load_i) begin
                count_q <= load_val_i;
            end else if (tick_i && (count_q != '0)) begin
                count_q <= count_q - 1'b1;
                if (count_q == QUANTA_W'(1)) expired_q <= 1'b1;
            end
        end
    end

    always_comb count_o   = count_q;
    always_comb expired_o = expired_q;

    // R6
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == '0 && !load_i) |=> (count_q == '0));

    // R6
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i) |=> (count_q == $past(count_q) || count_q == $past(count_q) - 1'b1));

    // R9
    expiry_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expired_q |-> (count_q == '0));
endmodule

// File: rtl/pause_flow_ctl.sv
// Module: pause_flow_ctl
// Receive-side flow-control pause handling: qualifies frames, loads and runs the
// pause countdown, blocks new transmit starts, and raises interrupts and statistics.
// Assumes: rx_frame_done is a one-cycle strobe; tx_busy is high while a frame is sent.
module pause_flow_ctl
    import pause_pkg::*;
#(
    parameter int QUANTUM_CLKS = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_full_duplex,
    input  logic                 cfg_pause_en,
    input  logic                 cfg_fast_count,
    input  logic [ADDR_W-1:0]    cfg_station_addr,
    input  logic                 irq_en_pause_rx,
    input  logic                 irq_en_pause_done,
    input  logic                 rx_frame_done,
    input  logic [ADDR_W-1:0]    rx_dst_addr,
    input  logic [FIELD_W-1:0]   rx_type,
    input  logic [FIELD_W-1:0]   rx_opcode,
    input  logic [QUANTA_W-1:0]  rx_pause_quanta,
    input  logic                 rx_frame_ok,
    input  logic                 tx_busy,
    output logic                 tx_hold,
    output logic [QUANTA_W-1:0]  pause_remaining,
    output logic                 irq_pause_rx,
    output logic                 irq_pause_done,
    output logic                 stat_pause_rx_inc
);
    logic frame_valid;
    logic do_load;
    logic run_cnt;
    logic tick;
    logic expired;
    logic [QUANTA_W-1:0] count;
    logic irq_rx_q;
    logic stat_q;

    pause_frame_qualify u_qualify (
        .frame_done_i (rx_frame_done),
        .frame_ok_i   (rx_frame_ok),
        .dst_i        (rx_dst_addr),
        .type_i       (rx_type),
        .opcode_i     (rx_opcode),
        .station_i    (cfg_station_addr),
        .valid_o      (frame_valid)
    );

    // Load only in full duplex, whatever the pause enable says.
    always_comb do_load = frame_valid && cfg_full_duplex;

    // Run while non-zero; with pausing enabled, only while the transmitter is idle.
    always_comb run_cnt = (count != '0) && (!cfg_pause_en || !tx_busy);

    pause_quanta_prescaler #(.QUANTUM_CLKS(QUANTUM_CLKS)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_cnt),
        .restart_i (do_load),
        .fast_i    (cfg_fast_count),
        .tick_o    (tick)
    );

    pause_time_counter #(.QUANTA_W(QUANTA_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (do_load),
        .load_val_i (rx_pause_quanta),
        .tick_i     (tick),
        .count_o    (count),
        .expired_o  (expired)
    );

    // Per-frame pulses: the statistic in either duplex mode, the interrupt behind its enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_rx_q <= 1'b0;
            stat_q   <= 1'b0;
        end else begin
            irq_rx_q <= frame_valid && irq_en_pause_rx;
            stat_q   <= frame_valid;
        end
    end

    // Output drive: the hold blocks only new frame starts.
    always_comb tx_hold           = cfg_pause_en && cfg_full_duplex && (count != '0);
    always_comb pause_remaining   = count;
    always_comb irq_pause_rx      = irq_rx_q;
    always_comb stat_pause_rx_inc = stat_q;
    always_comb irq_pause_done    = expired && irq_en_pause_done;

    // R2
    bad_frame_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_frame_done && !rx_frame_ok) |=> !stat_pause_rx_inc);

    // R7
    frozen_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_pause_en && tx_busy && !rx_frame_done) |=> $stable(pause_remaining));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pause_done |=> !irq_pause_done);

    // R4
    irq_with_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pause_rx |-> stat_pause_rx_inc);
endmodule

// File: tb/test_pause_flow_ctl.sv
`timescale 1ns/1ps
module test_pause_flow_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_full_duplex = 1'b1, cfg_pause_en = 1'b1, cfg_fast_count = 1'b0;
    logic [47:0] cfg_station_addr = 48'h001122334455;
    logic        irq_en_pause_rx = 1'b1, irq_en_pause_done = 1'b1;
    logic        rx_frame_done = 1'b0;
    logic [47:0] rx_dst_addr = '0;
    logic [15:0] rx_type = '0, rx_opcode = '0, rx_pause_quanta = '0;
    logic        rx_frame_ok = 1'b0;
    logic        tx_busy = 1'b0;
    logic        tx_hold, irq_pause_rx, irq_pause_done, stat_pause_rx_inc;
    logic [15:0] pause_remaining;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    localparam logic [47:0] MC = 48'h0180C2000001;
    localparam logic [47:0] ST = 48'h001122334455;

    // Fields: dst[99:52] type[51:36] op[35:20] ok[19] fd[18] quanta[17:2] exp_valid[1] exp_load[0]
    localparam logic [99:0] VECS [0:7] = '{
        {MC, 16'h8808, 16'h0001, 1'b1, 1'b1, 16'h0010, 1'b1, 1'b1},
        {ST, 16'h8808, 16'h0001, 1'b1, 1'b1, 16'h0020, 1'b1, 1'b1},
        {48'h0180C2000002, 16'h8808, 16'h0001, 1'b1, 1'b1, 16'h0030, 1'b0, 1'b0},
        {MC, 16'h0800, 16'h0001, 1'b1, 1'b1, 16'h0031, 1'b0, 1'b0},
        {MC, 16'h8808, 16'h0002, 1'b1, 1'b1, 16'h0032, 1'b0, 1'b0},
        {MC, 16'h8808, 16'h0001, 1'b0, 1'b1, 16'h0033, 1'b0, 1'b0},
        {MC, 16'h8808, 16'h0001, 1'b1, 1'b0, 16'h0040, 1'b1, 1'b0},
        {ST, 16'h8808, 16'h0001, 1'b1, 1'b1, 16'h0003, 1'b1, 1'b1}
    };

    pause_flow_ctl i_pause_flow_ctl (.*);

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic send(input logic [47:0] dst, input logic [15:0] ty, input logic [15:0] op,
                        input logic ok, input logic [15:0] q);
        rx_dst_addr = dst; rx_type = ty; rx_opcode = op; rx_frame_ok = ok;
        rx_pause_quanta = q; rx_frame_done = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rx_frame_done = 1'b0;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] prev;
        step(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 tx_hold", tx_hold, 0);
        chk("R10 remaining", pause_remaining, 0);
        chk("R10 irq_rx", irq_pause_rx, 0);
        chk("R10 irq_done", irq_pause_done, 0);
        chk("R10 stat", stat_pause_rx_inc, 0);

        // Table walk: counter frozen (pause enabled, transmitter busy)
        tx_busy = 1'b1;
        for (int i = 0; i < 8; i++) begin
            logic [99:0] v;
            v = VECS[i];
            cfg_full_duplex = v[18];
            prev = pause_remaining;
            send(v[99:52], v[51:36], v[35:20], v[19], v[17:2]);
            chk("R1/R2 stat pulse", stat_pause_rx_inc, v[1]);
            chk("R4 irq_rx pulse", irq_pause_rx, v[1]);
            chk("R3 load", pause_remaining, v[0] ? v[17:2] : prev);
            chk("R5 tx_hold", tx_hold, (v[18] && pause_remaining != 0) ? 1 : 0);
        end
        cfg_full_duplex = 1'b1;

        // R3: load with pausing disabled still takes effect
        cfg_pause_en = 1'b0;
        send(MC, 16'h8808, 16'h0001, 1'b1, 16'h0050);
        chk("R3 load while disabled", pause_remaining, 16'h0050);
        chk("R5 no hold while disabled", tx_hold, 0);

        // R7: disabled pausing counts even when busy (fast mode)
        cfg_fast_count = 1'b1;
        send(MC, 16'h8808, 16'h0001, 1'b1, 16'h0004);
        step(1);
        chk("R7 counts while busy, disabled", pause_remaining, 3);
        // R7: enabled pausing freezes while busy
        cfg_pause_en = 1'b1;
        step(10);
        chk("R7 frozen while busy", pause_remaining, 3);
        chk("R5 hold while non-zero", tx_hold, 1);

        // R8 / R9: fast countdown to expiry with idle transmitter
        tx_busy = 1'b0;
        step(2);
        chk("R8 fast decrement", pause_remaining, 1);
        step(1);
        chk("R8 reaches zero", pause_remaining, 0);
        chk("R9 expiry pulse", irq_pause_done, 1);
        chk("R5 hold released", tx_hold, 0);
        step(1);
        chk("R9 pulse one cycle", irq_pause_done, 0);

        // R9 / R4: enables low suppress interrupts but not the statistic
        irq_en_pause_rx = 1'b0; irq_en_pause_done = 1'b0;
        send(ST, 16'h8808, 16'h0001, 1'b1, 16'h0001);
        chk("R4 stat with irq disabled", stat_pause_rx_inc, 1);
        chk("R4 irq_rx disabled", irq_pause_rx, 0);
        step(1);
        chk("R9 expiry with enable low", {pause_remaining, 15'd0, irq_pause_done}, 0);
        irq_en_pause_rx = 1'b1; irq_en_pause_done = 1'b1;

        // R9: load of zero raises no expiry
        tx_busy = 1'b1;
        send(MC, 16'h8808, 16'h0001, 1'b1, 16'h0005);
        send(MC, 16'h8808, 16'h0001, 1'b1, 16'h0000);
        chk("R9 zero load", pause_remaining, 0);
        step(1);
        chk("R9 no pulse on zero load", irq_pause_done, 0);

        // R6: 128-clock quantum after a load
        cfg_fast_count = 1'b0; tx_busy = 1'b0;
        send(MC, 16'h8808, 16'h0001, 1'b1, 16'h0002);
        step(127);
        chk("R6 before quantum end", pause_remaining, 2);
        step(1);
        chk("R6 at quantum end", pause_remaining, 1);
        // R6: reload mid-quantum restarts the prescaler
        step(60);
        send(MC, 16'h8808, 16'h0001, 1'b1, 16'h0007);
        step(127);
        chk("R6 restart before end", pause_remaining, 7);
        step(1);
        chk("R6 restart at end", pause_remaining, 6);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule